// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps an effective address onto a physical address through a small set of block mappings. Each mapping, called a pair, holds a block base, a size mask and two enable bits in its upper word, and a physical block base in its lower word. A block spans 128 KB times a power of two. Address bits 16 down to 0 always pass through unchanged. Each bit that the size mask sets is taken from the effective address, and every other page bit is taken from the physical base.

The lookup is combinational, working from the effective address and the stored pairs. It drives a hit flag and the translated address. On a hit, the caller uses this address and does not start a page-table walk. A second flag, `ram_hit`, tells whether the physical target lies in one of three memory windows: main RAM, extended RAM or the locked cache. A warning vector marks each enabled pair whose setup is suspect but which still translates. One instance is intended for instruction fetch and another for data access.

The pairs are loaded through a single write port, one word per cycle. A written word is used from the clock edge that stores it.

Top module: `bxlat_unit`

## Requirements
- R1: After reset, every pair reads as all zero. With no write made, `hit`, `ram_hit`, `pa` and `cfg_warn` are all 0 for any `ea`.
- R2: A pair whose supervisor-enable bit (upper bit 1) and user-enable bit (upper bit 0) are both 0 never matches, and its `cfg_warn` bit is 0.
- R3: An enabled pair matches when `(ea[31:17] & ~mask) == base`, where the 11-bit mask is zero-extended to 15 bits. On a match, `pa[31:17] = phys | (ea[31:17] & mask)` and `pa[16:0] = ea[16:0]`.
- R4: A pair whose base has a bit set in common with its mask never matches, and its `cfg_warn` bit is 0.
- R5: An enabled pair whose phys base has a bit set in common with its mask raises its `cfg_warn` bit, and it still translates as in R3.
- R6: An enabled pair whose mask plus one is not a power of two (a mask that is not a run of ones from bit 0) raises its `cfg_warn` bit, and it still translates as in R3.
- R7: When several pairs match, the pair with the lowest index sets `pa`.
- R8: `ram_hit` is 1 only on a hit whose `pa` lies in one of three windows: [0x00000000, 0x01800000), [0x10000000, 0x14000000) or [0xE0000000, 0xE0004000).
- R9: A write with `wr_upper`=1 loads the upper word of pair `wr_sel`, laid out as base [27:13], mask [12:2], supervisor enable [1] and user enable [0]. A write with `wr_upper`=0 loads the phys base from `wr_data[27:13]`. The new contents steer the lookup only after the clock edge that stores them.
- R10: Setting either enable bit alone enables the pair.
- R11: On a miss, `pa` and `ram_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the pair registers |
| wr_sel | input | $clog2(NUM_PAIRS) | Index of the pair to write |
| wr_upper | input | 1 | 1 selects the upper word, 0 the lower word |
| wr_data | input | 28 | Write data |
| ea | input | 32 | Effective address |
| hit | output | 1 | A pair matched |
| pa | output | 32 | Translated physical address, 0 on a miss |
| ram_hit | output | 1 | The hit lands in a memory window |
| cfg_warn | output | NUM_PAIRS | Per-pair flag for a suspect setup |

## Verification
The assertions are checked on every cycle. They cover these properties: a miss always drives a cleared address and a cleared window flag, the window flag never appears without a hit, and the offset bits always pass through on a hit. They also check that, with no write, a held effective address keeps every output steady. The bench scenarios cover what depends on register contents. These are the mask-based match and merge, the rejection of a base that overlaps its mask, the two warning cases that still translate, lowest-index priority, the window edges and the cycle at which a write takes effect.

// File: rtl/bxlat_pkg.sv
package bxlat_pkg;
  localparam int ADDR_W  = 32;
  localparam int BLK_LSB = 17;
  localparam int PG_W    = ADDR_W - BLK_LSB;
  localparam int BL_W    = 11;
  localparam int WD_W    = PG_W + BL_W + 2;

  typedef struct packed {
    logic [PG_W-1:0] base;
    logic [BL_W-1:0] mask;
    logic            sv;
    logic            uv;
  } upper_t;

  typedef struct packed {
    upper_t          up;
    logic [PG_W-1:0] phys;
  } pair_t;
endpackage

// File: rtl/bxlat_regs.sv
module bxlat_regs
  import bxlat_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_PAIRS)-1:0] wr_sel,
  input  logic                         wr_upper,
  input  logic [WD_W-1:0]              wr_data,
  output pair_t                        pairs [NUM_PAIRS]
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  pair_t      pairs_d [NUM_PAIRS];
  pair_t      pairs_q [NUM_PAIRS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    pairs_d = pairs_q;
    if (wr_upper) pairs_d[wr_sel].up   = wr_data;
    else          pairs_d[wr_sel].phys = wr_data[WD_W-1 -: PG_W];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < NUM_PAIRS; i++) pairs_q[i] <= '0;
    end else if (wr_en) begin
      pairs_q <= pairs_d;
    end
  end

  assign pairs = pairs_q;
endmodule

// File: rtl/bxlat_match.sv
module bxlat_match
  import bxlat_pkg::*;
(
  input  pair_t           pair,
  input  logic [PG_W-1:0] ea_pg,
  output logic            match,
  output logic [PG_W-1:0] pg_out,
  output logic            warn
);
  logic [PG_W-1:0] mask_x;
  logic [BL_W:0]   mask_p1;
  logic            enabled, base_bad, phys_ovl, not_run;

  assign mask_x   = {{(PG_W-BL_W){1'b0}}, pair.up.mask};
  assign mask_p1  = {1'b0, pair.up.mask} + (BL_W+1)'(1);
  assign enabled  = pair.up.sv | pair.up.uv;
  assign base_bad = |(pair.up.base & mask_x);
  assign phys_ovl = |(pair.phys & mask_x);
  assign not_run  = |(mask_p1 & {1'b0, pair.up.mask});

  assign match  = enabled & ~base_bad & ((ea_pg & ~mask_x) == pair.up.base);
  assign pg_out = pair.phys | (ea_pg & mask_x);
  assign warn   = enabled & ~base_bad & (phys_ovl | not_run);
endmodule

// File: rtl/bxlat_prio.sv
module bxlat_prio
  import bxlat_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  logic [NUM_PAIRS-1:0] match,
  input  logic [PG_W-1:0]      pg_in [NUM_PAIRS],
  output logic                 hit,
  output logic [PG_W-1:0]      pg_sel
);
  always_comb begin
    hit    = 1'b0;
    pg_sel = '0;
    for (int i = NUM_PAIRS-1; i >= 0; i--) begin
      if (match[i]) begin
        hit    = 1'b1;
        pg_sel = pg_in[i];
      end
    end
  end
endmodule

// File: rtl/bxlat_unit.sv
module bxlat_unit
  import bxlat_pkg::*;
#(
  parameter int                NUM_PAIRS = 4,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] MAIN_SIZE = 32'h0180_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE  = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] EXT_SIZE  = 32'h0400_0000,
  parameter logic [ADDR_W-1:0] LOCK_BASE = 32'hE000_0000,
  parameter logic [ADDR_W-1:0] LOCK_SIZE = 32'h0000_4000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_PAIRS)-1:0] wr_sel,
  input  logic                         wr_upper,
  input  logic [WD_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]            ea,
  output logic                         hit,
  output logic [ADDR_W-1:0]            pa,
  output logic                         ram_hit,
  output logic [NUM_PAIRS-1:0]         cfg_warn
);
  pair_t                 pairs [NUM_PAIRS];
  logic [NUM_PAIRS-1:0]  match;
  logic [PG_W-1:0]       pg_each [NUM_PAIRS];
  logic [PG_W-1:0]       pg_sel;
  logic                  hit_c;
  logic                  in_main, in_ext, in_lock;

  bxlat_regs #(.NUM_PAIRS(NUM_PAIRS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_upper(wr_upper), .wr_data(wr_data), .pairs(pairs)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    bxlat_match match_i (
      .pair(pairs[i]), .ea_pg(ea[ADDR_W-1:BLK_LSB]),
      .match(match[i]), .pg_out(pg_each[i]), .warn(cfg_warn[i])
    );
  end

  bxlat_prio #(.NUM_PAIRS(NUM_PAIRS)) prio_i (
    .match(match), .pg_in(pg_each), .hit(hit_c), .pg_sel(pg_sel)
  );

  assign hit = hit_c;
  assign pa  = hit_c ? {pg_sel, ea[BLK_LSB-1:0]} : '0;

  assign in_main = (pa - MAIN_BASE) < MAIN_SIZE;
  assign in_ext  = (pa - EXT_BASE)  < EXT_SIZE;
  assign in_lock = (pa - LOCK_BASE) < LOCK_SIZE;
  assign ram_hit = hit_c & (in_main | in_ext | in_lock);
endmodule

// File: rtl/bxlat_unit_chk.sv
module bxlat_unit_chk
  import bxlat_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    ea,
  input logic                 hit,
  input logic [ADDR_W-1:0]    pa,
  input logic                 ram_hit,
  input logic [NUM_PAIRS-1:0] cfg_warn
);
  // R11
  pa_clear_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (pa == '0) && !ram_hit);

  // R8
  ram_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_hit |-> hit);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pa[BLK_LSB-1:0] == ea[BLK_LSB-1:0]);

  // R9
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(ea)) |->
      ($stable(hit) && $stable(pa) && $stable(ram_hit) && $stable(cfg_warn)));
endmodule

bind bxlat_unit bxlat_unit_chk #(.NUM_PAIRS(NUM_PAIRS)) chk_i (.*);

// File: tb/bxlat_unit_test.sv
module bxlat_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic        wr_upper = 1'b0;
  logic [27:0] wr_data = '0;
  logic [31:0] ea = '0;
  logic        hit, ram_hit;
  logic [31:0] pa;
  logic [3:0]  cfg_warn;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  bxlat_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_upper(wr_upper), .wr_data(wr_data), .ea(ea),
    .hit(hit), .pa(pa), .ram_hit(ram_hit), .cfg_warn(cfg_warn)
  );

  always #5 clk = ~clk;

  function automatic logic [27:0] mk_up(logic [14:0] b, logic [10:0] m, logic s, logic u);
    return {b, m, s, u};
  endfunction

  function automatic logic [27:0] mk_lo(logic [14:0] p);
    return {p, 13'h0};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(string tag, logic eh, logic [31:0] ep, logic er);
    n_chk++;
    if ({hit, pa, ram_hit} !== {eh, ep, er}) begin
      n_fail++;
      $display("FAIL %s ea=%h: hit=%b pa=%h ram=%b expected hit=%b pa=%h ram=%b",
               tag, ea, hit, pa, ram_hit, eh, ep, er);
    end
  endtask

  task automatic chkw(string tag, logic [3:0] ew);
    n_chk++;
    if (cfg_warn !== ew) begin
      n_fail++;
      $display("FAIL %s: warn=%b expected warn=%b", tag, cfg_warn, ew);
    end
  endtask

  task automatic wr(logic [1:0] s, logic up, logic [27:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_upper = up; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(logic [31:0] a);
    ea = a;
    #1;
  endtask

  task automatic t_reset();
    look(32'h0000_0000); chk("R1 reset zero ea", 0, 32'h0, 0);
    look(32'h8012_3456); chk("R1 reset other ea", 0, 32'h0, 0);
    chkw("R1 reset warn", 4'b0000);
  endtask

  task automatic t_disabled();
    wr(0, 0, mk_lo(15'h0080));
    wr(0, 1, mk_up(15'h0001, 11'h000, 0, 0));
    look(32'h0002_0000); chk("R2 disabled pair", 0, 32'h0, 0);
    chkw("R2 disabled warn", 4'b0000);
  endtask

  task automatic t_basic();
    wr(0, 0, mk_lo(15'h0000));
    wr(0, 1, mk_up(15'h4000, 11'h00F, 1, 0));
    look(32'h8012_3456); chk("R3 merge", 1, 32'h0012_3456, 1);
    look(32'h801F_FFFF); chk("R3 top of block", 1, 32'h001F_FFFF, 1);
    look(32'h8020_0000); chk("R3 past block", 0, 32'h0, 0);
    look(32'h2000_0000); chk("R11 miss", 0, 32'h0, 0);
    wr(0, 1, mk_up(15'h4000, 11'h00F, 0, 1));
    look(32'h8012_3456); chk("R10 user enable only", 1, 32'h0012_3456, 1);
    chkw("R3 clean warn", 4'b0000);
  endtask

  task automatic t_bad_base();
    wr(1, 1, mk_up(15'h0801, 11'h001, 1, 1));
    look(32'h1002_0000); chk("R4 overlap never matches", 0, 32'h0, 0);
    chkw("R4 overlap no warn", 4'b0000);
  endtask

  task automatic t_phys_ovl();
    wr(1, 0, mk_lo(15'h0802));
    wr(1, 1, mk_up(15'h0800, 11'h003, 1, 0));
    look(32'h1002_0010); chk("R5 still translates", 1, 32'h1006_0010, 1);
    chkw("R5 warn", 4'b0010);
  endtask

  task automatic t_not_run();
    wr(2, 0, mk_lo(15'h7000));
    wr(2, 1, mk_up(15'h7000, 11'h005, 1, 0));
    look(32'hE000_0100); chk("R6 translates R8 lock window", 1, 32'hE000_0100, 1);
    look(32'hE000_4000); chk("R8 lock window end", 1, 32'hE000_4000, 0);
    look(32'hE008_0000); chk("R6 gap mask bit", 1, 32'hE008_0000, 0);
    chkw("R6 warn", 4'b0110);
  endtask

  task automatic t_windows();
    wr(3, 0, mk_lo(15'h00B8));
    wr(3, 1, mk_up(15'h6000, 11'h007, 1, 0));
    look(32'hC00F_FFFF); chk("R8 main window last byte", 1, 32'h017F_FFFF, 1);
    wr(3, 0, mk_lo(15'h00C0));
    look(32'hC000_0000); chk("R8 main window end", 1, 32'h0180_0000, 0);
    chkw("R8 warn unchanged", 4'b0110);
  endtask

  task automatic t_prio();
    wr(3, 1, mk_up(15'h4000, 11'h00F, 1, 0));
    look(32'h8012_3456); chk("R7 lowest pair wins", 1, 32'h0012_3456, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_upper = 1'b1; wr_data = mk_up(15'h4000, 11'h00F, 0, 0);
    #1; chk("R9 before edge", 1, 32'h0012_3456, 1);
    @(negedge clk);
    wr_en = 1'b0;
    #1; chk("R9 after edge R7 next pair", 1, 32'h0192_3456, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_bad_base();
    t_phys_ovl();
    t_not_run();
    t_windows();
    t_prio();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
    end
  end
endmodule